// File: doc/BRIEF.md
# Light-Load Burst Controller

This block decides when a quasi-resonant flyback controller leaves its normal valley-switching operation for a low-power burst mode, how it switches while in that mode, and when it returns. It takes synchronous comparator flags that describe the regulation voltage: below the entry level, above the burst-on level, below the burst-off level and above the leave level. It also takes the current valley-skip count, a current-sense trip flag, a protection-fault input and a timing tick enable.

Entry is qualified over a blanking window. The regulation voltage must stay low and the valley-skip count must stay at its maximum for the whole window. Once in burst mode, switching follows hysteresis on the regulation voltage. While switching is allowed, a fixed-period timer starts each gate pulse. A pulse ends on a current-sense trip or at half the period, whichever comes first. A high regulation voltage ends burst mode at once, and a one-cycle pulse then tells the valley-skip counter to load its minimum value.

Top module: `lightload_burst_ctrl`

## Requirements
- R1: Burst mode (`burst_mode_o`=1) is entered at the clock edge that completes BLANK_CYC consecutive ticked cycles in which `reg_below_entry_i`=1 and `valley_cnt_i` equals VALLEY_MAX (7 by default). The change is visible in the cycle after that edge.
- R2: If either entry condition is false in any cycle, the blanking count restarts from zero, and burst mode is not entered until a full new window has passed.
- R3: Switching is disabled when burst mode is entered. In burst mode it turns on when `reg_above_on_i`=1 and turns off when `reg_below_off_i`=1; on wins if both are set in the same cycle. `gate_req_o` is never 1 while switching is off.
- R4: While switching is on, a gate pulse starts in the cycle after switching turns on, and a new one starts every PERIOD_CYC ticked cycles after that.
- R5: A gate pulse lasts at most PERIOD_CYC/2 ticked cycles, rounded down.
- R6: When `cs_trip_i`=1 during a gate pulse, `gate_req_o` is 0 in the next cycle and stays 0 until the next period starts.
- R7: In burst mode, `reg_above_leave_i`=1 clears `burst_mode_o` and `gate_req_o` in the next cycle. `valley_set1_o` is 1 for exactly that one cycle.
- R8: `low_ilim_o` equals `burst_mode_o`, and `normal_on_en_o` is its inverse, so the valley-triggered switch-on path is disabled throughout burst mode.
- R9: A synchronous reset or `fault_i`=1 returns the block to normal mode with `gate_req_o`=0, produces no `valley_set1_o` pulse, and restarts the blanking window.
- R10: When `tick_i`=0, both the blanking count and the burst period timer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Enable that advances the blanking count and the period timer |
| fault_i | input | 1 | Protection fault; forces normal mode |
| reg_below_entry_i | input | 1 | Regulation voltage is below the entry level |
| reg_above_on_i | input | 1 | Regulation voltage is above the burst-on level |
| reg_below_off_i | input | 1 | Regulation voltage is below the burst-off level |
| reg_above_leave_i | input | 1 | Regulation voltage is above the leave level |
| valley_cnt_i | input | VALLEY_W | Current valley-skip count |
| cs_trip_i | input | 1 | Current sense has reached the burst current limit |
| burst_mode_o | output | 1 | Block is in burst mode |
| gate_req_o | output | 1 | Gate request from the burst PWM |
| low_ilim_o | output | 1 | Selects the reduced current limit |
| valley_set1_o | output | 1 | One-cycle pulse that loads 1 into the valley-skip counter |
| normal_on_en_o | output | 1 | Enables the normal valley-triggered switch-on path |

## Verification
The entry path is tested three ways: with a window held while ticks are stopped, with a window broken one cycle before it would complete, and with a full window. These three cases separate timer freezing, window restart and the correct entry edge. Inside burst mode, the bench drives a burst-on edge, a current-sense trip in the middle of a period, a burst-off edge and a tick stall. This shows the pulse start and cap, trip truncation, the hysteresis and timer freezing as distinct effects. Leave, fault during burst and fault during blanking tell the exit pulse apart from a silent return to normal mode. A long run of mixed random flags is then compared against the behavioural model on every cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_BURST  = 1'b1
    } burst_mode_e;

    typedef struct packed {
        logic below_entry;
        logic above_on;
        logic below_off;
        logic above_leave;
    } reg_flags_t;

endpackage

// File: rtl/burst_entry_qual.sv
module burst_entry_qual #(
    parameter int BLANK_CYC  = 2400000,
    parameter int VALLEY_W   = 3,
    parameter int VALLEY_MAX = 7
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  logic                clr_i,
    input  logic                below_entry_i,
    input  logic [VALLEY_W-1:0] valley_cnt_i,
    output logic                enter_o
);
    localparam int CNT_W = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
    localparam logic [CNT_W-1:0]    LAST_V = CNT_W'(BLANK_CYC - 1);
    localparam logic [VALLEY_W-1:0] TOP_V  = VALLEY_W'(VALLEY_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;
    logic  cond;

    always_comb begin
        qual_d  = qual_q;
        cond    = below_entry_i && (valley_cnt_i == TOP_V) && !clr_i;
        enter_o = cond && tick_i && (qual_q.cnt == LAST_V);
        if (!cond) begin
            qual_d.cnt = '0;
        end else if (tick_i) begin
            qual_d.cnt = (qual_q.cnt == LAST_V) ? '0 : qual_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            qual_q <= '0;
        end else begin
            qual_q <= qual_d;
        end
    end

    AST_ENTER_NEEDS_COND: assert property (@(posedge clk_i) disable iff (rst_i)
        enter_o |-> (below_entry_i && !clr_i && tick_i)); // R1

    AST_WINDOW_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        !below_entry_i |=> (qual_q.cnt == '0)); // R2

    AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && below_entry_i && (valley_cnt_i == TOP_V) && !clr_i) |=> $stable(qual_q.cnt)); // R10

endmodule

// File: rtl/burst_pwm.sv
module burst_pwm #(
    parameter int PERIOD_CYC = 1250
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic run_i,
    input  logic cs_trip_i,
    output logic gate_o
);
    localparam int PC_W = $clog2(PERIOD_CYC);
    localparam int HALF = PERIOD_CYC / 2;
    localparam logic [PC_W-1:0] LAST_V = PC_W'(PERIOD_CYC - 1);
    localparam logic [PC_W-1:0] HALF_V = PC_W'(HALF);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            trip;
        logic            gate;
        logic            run;
    } pwm_t;

    pwm_t pwm_d, pwm_q;
    logic wrap;

    always_comb begin
        pwm_d = pwm_q;
        wrap  = tick_i && (pwm_q.pc == LAST_V);
        if (!run_i) begin
            pwm_d = '0;
        end else begin
            pwm_d.run = 1'b1;
            if (!pwm_q.run) begin
                pwm_d.pc   = '0;
                pwm_d.trip = 1'b0;
            end else begin
                if (tick_i) begin
                    pwm_d.pc = wrap ? '0 : pwm_q.pc + 1'b1;
                end
                pwm_d.trip = wrap ? 1'b0 : (pwm_q.trip || (cs_trip_i && pwm_q.gate));
            end
            pwm_d.gate = (pwm_d.pc < HALF_V) && !pwm_d.trip;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pwm_q <= '0;
        end else begin
            pwm_q <= pwm_d;
        end
    end

    assign gate_o = pwm_q.gate;

    logic [PC_W:0] on_ticks_q;
    always_ff @(posedge clk_i) begin
        if (rst_i || !pwm_q.gate) begin
            on_ticks_q <= '0;
        end else if (tick_i) begin
            on_ticks_q <= on_ticks_q + 1'b1;
        end
    end

    AST_ON_TIME_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        pwm_q.gate |-> (on_ticks_q < (PC_W+1)'(HALF))); // R5

    AST_TRIP_ENDS_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwm_q.gate && cs_trip_i) |=> !pwm_q.gate); // R6

    AST_START_ON_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !pwm_q.run) |=> pwm_q.gate); // R4

endmodule

// File: rtl/lightload_burst_ctrl.sv
module lightload_burst_ctrl
    import burst_pkg::*;
#(
    parameter int PERIOD_CYC = 1250,
    parameter int BLANK_CYC  = 2400000,
    parameter int VALLEY_W   = 3,
    parameter int VALLEY_MAX = 7
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  logic                fault_i,
    input  logic                reg_below_entry_i,
    input  logic                reg_above_on_i,
    input  logic                reg_below_off_i,
    input  logic                reg_above_leave_i,
    input  logic [VALLEY_W-1:0] valley_cnt_i,
    input  logic                cs_trip_i,
    output logic                burst_mode_o,
    output logic                gate_req_o,
    output logic                low_ilim_o,
    output logic                valley_set1_o,
    output logic                normal_on_en_o
);
    localparam logic [VALLEY_W-1:0] TOP_V = VALLEY_W'(VALLEY_MAX);

    typedef struct packed {
        burst_mode_e mode;
        logic        sw_en;
        logic        exit_pls;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    reg_flags_t flags;
    logic       enter, qual_clr, run, leave;

    assign flags    = '{below_entry: reg_below_entry_i, above_on: reg_above_on_i,
                        below_off: reg_below_off_i, above_leave: reg_above_leave_i};
    assign qual_clr = fault_i || (ctl_q.mode == MODE_BURST);

    burst_entry_qual #(
        .BLANK_CYC (BLANK_CYC),
        .VALLEY_W  (VALLEY_W),
        .VALLEY_MAX(VALLEY_MAX)
    ) u_qual (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tick_i       (tick_i),
        .clr_i        (qual_clr),
        .below_entry_i(flags.below_entry),
        .valley_cnt_i (valley_cnt_i),
        .enter_o      (enter)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.exit_pls = 1'b0;
        leave          = (ctl_q.mode == MODE_BURST) && flags.above_leave;
        if (fault_i) begin
            ctl_d.mode  = MODE_NORMAL;
            ctl_d.sw_en = 1'b0;
        end else if (ctl_q.mode == MODE_BURST) begin
            if (leave) begin
                ctl_d.mode     = MODE_NORMAL;
                ctl_d.sw_en    = 1'b0;
                ctl_d.exit_pls = 1'b1;
            end else if (flags.above_on) begin
                ctl_d.sw_en = 1'b1;
            end else if (flags.below_off) begin
                ctl_d.sw_en = 1'b0;
            end
        end else begin
            ctl_d.sw_en = 1'b0;
            if (enter) begin
                ctl_d.mode = MODE_BURST;
            end
        end
        run = (ctl_d.mode == MODE_BURST) && ctl_d.sw_en;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '{mode: MODE_NORMAL, sw_en: 1'b0, exit_pls: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    burst_pwm #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_pwm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .run_i    (run),
        .cs_trip_i(cs_trip_i),
        .gate_o   (gate_req_o)
    );

    assign burst_mode_o   = (ctl_q.mode == MODE_BURST);
    assign low_ilim_o     = burst_mode_o;
    assign normal_on_en_o = !burst_mode_o;
    assign valley_set1_o  = ctl_q.exit_pls;

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(burst_mode_o) |-> $past(reg_below_entry_i && (valley_cnt_i == TOP_V))); // R1

    AST_GATE_NEEDS_BURST: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_req_o |-> burst_mode_o); // R3

    AST_EXIT_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        valley_set1_o |=> !valley_set1_o); // R7

    AST_EXIT_FROM_LEAVE: assert property (@(posedge clk_i) disable iff (rst_i)
        valley_set1_o |-> (!burst_mode_o && $past(burst_mode_o && reg_above_leave_i))); // R7

    AST_FAULT_TO_NORMAL: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_i |=> (!burst_mode_o && !gate_req_o && !valley_set1_o)); // R9

endmodule

// File: tb/lightload_burst_ctrl_tb_top.sv
module lightload_burst_ctrl_tb_top;
    localparam int P  = 10;
    localparam int H  = P / 2;
    localparam int B  = 20;
    localparam int VW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1, fault = 1'b0;
    logic below_entry = 1'b0, above_on = 1'b0, below_off = 1'b0, above_leave = 1'b0;
    logic [VW-1:0] valley = '0;
    logic cs_trip = 1'b0;
    logic burst_mode, gate_req, low_ilim, valley_set1, normal_en;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lightload_burst_ctrl #(
        .PERIOD_CYC(P), .BLANK_CYC(B), .VALLEY_W(VW), .VALLEY_MAX(7)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .fault_i(fault),
        .reg_below_entry_i(below_entry), .reg_above_on_i(above_on),
        .reg_below_off_i(below_off), .reg_above_leave_i(above_leave),
        .valley_cnt_i(valley), .cs_trip_i(cs_trip),
        .burst_mode_o(burst_mode), .gate_req_o(gate_req), .low_ilim_o(low_ilim),
        .valley_set1_o(valley_set1), .normal_on_en_o(normal_en)
    );

    // Behavioural reference
    bit m_burst = 0, m_sw = 0, m_trip = 0, m_gate = 0, m_runp = 0, m_pulse = 0;
    int m_blank = 0, m_pc = 0;

    always @(posedge clk) begin : model
        bit nb, ns, lv, cond, wrap;
        if (rst) begin
            m_burst = 0; m_sw = 0; m_trip = 0; m_gate = 0; m_runp = 0;
            m_pulse = 0; m_blank = 0; m_pc = 0;
        end else begin
            nb = m_burst; ns = m_sw; m_pulse = 0;
            lv = m_burst && above_leave;
            cond = below_entry && (valley == 7) && !m_burst && !fault;
            if (!cond) m_blank = 0;
            else if (tick) begin
                if (m_blank == B - 1) begin m_blank = 0; nb = 1; end
                else m_blank = m_blank + 1;
            end
            if (fault) begin nb = 0; ns = 0; end
            else if (m_burst) begin
                if (lv) begin nb = 0; ns = 0; m_pulse = 1; end
                else if (above_on) ns = 1;
                else if (below_off) ns = 0;
            end else ns = 0;
            if (!(nb && ns)) begin
                m_pc = 0; m_trip = 0; m_gate = 0; m_runp = 0;
            end else begin
                if (!m_runp) begin m_pc = 0; m_trip = 0; end
                else begin
                    wrap = tick && (m_pc == P - 1);
                    m_trip = wrap ? 0 : (m_trip || (cs_trip && m_gate));
                    if (tick) m_pc = wrap ? 0 : m_pc + 1;
                end
                m_gate = (m_pc < H) && !m_trip;
                m_runp = 1;
            end
            m_burst = nb; m_sw = ns;
        end
    end

    task automatic cmp(string tag, logic act, logic exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cmp("R1 burst_mode", burst_mode, m_burst);
            cmp("R4 gate_req", gate_req, m_gate);
            cmp("R7 valley_set1", valley_set1, m_pulse);
            cmp("R8 low_ilim", low_ilim, m_burst);
            cmp("R8 normal_on_en", normal_en, !m_burst);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic look;
        #4;
    endtask

    task automatic summary;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
        end
    end

    initial begin
        int hi, rises;
        logic prev;
        cyc(3);
        rst = 1'b0;
        look; cmp("R9 reset burst", burst_mode, 1'b0); cmp("R9 reset gate", gate_req, 1'b0);

        // R10: blanking frozen while ticks are stopped
        below_entry = 1; valley = 7; tick = 0;
        cyc(50); look; cmp("R10 no entry without ticks", burst_mode, 1'b0);
        tick = 1;
        // R2: break the window one cycle
        cyc(B - 2); valley = 6; cyc(1); valley = 7;
        cyc(B - 1); look; cmp("R2 window restarted", burst_mode, 1'b0);
        cyc(1); look; cmp("R1 entry after full window", burst_mode, 1'b1);
        cmp("R8 reduced limit", low_ilim, 1'b1); cmp("R8 normal path off", normal_en, 1'b0);
        below_entry = 0;
        cyc(5); look; cmp("R3 no switching before burst-on", gate_req, 1'b0);

        // R4/R5: pulses
        above_on = 1; cyc(1); above_on = 0;
        hi = 0; rises = 0; prev = 1'b0;
        for (int i = 0; i < 3 * P; i++) begin
            look;
            if (gate_req) hi++;
            if (gate_req && !prev) rises++;
            prev = gate_req;
            cyc(1);
        end
        cmp("R5 on-time is half period", logic'(hi == 3 * H), 1'b1);
        cmp("R4 one pulse per period", logic'(rises == 3), 1'b1);

        // R6: trip mid-pulse
        cs_trip = 1; cyc(1); cs_trip = 0;
        look; cmp("R6 trip ends pulse", gate_req, 1'b0);
        cyc(P - 2); look; cmp("R6 held low to period end", gate_req, 1'b0);
        cyc(1); look; cmp("R6 next period starts", gate_req, 1'b1);

        // R10: period timer frozen
        tick = 0; cyc(20); look; cmp("R10 pulse held without ticks", gate_req, 1'b1);
        tick = 1;

        // R3: burst-off
        below_off = 1; cyc(1); below_off = 0;
        look; cmp("R3 burst-off stops gate", gate_req, 1'b0);
        cyc(P); look; cmp("R3 stays off", gate_req, 1'b0);

        // R7: leave
        above_on = 1; cyc(1); above_on = 0; above_leave = 1; cyc(1); above_leave = 0;
        look; cmp("R7 leave clears burst", burst_mode, 1'b0);
        cmp("R7 exit pulse", valley_set1, 1'b1); cmp("R7 gate low", gate_req, 1'b0);
        cyc(1); look; cmp("R7 pulse one cycle", valley_set1, 1'b0);
        cmp("R8 normal path back", normal_en, 1'b1);

        // R9: fault in burst and during blanking
        below_entry = 1; cyc(B); look; cmp("R1 re-entry", burst_mode, 1'b1);
        above_on = 1; fault = 1; cyc(1); fault = 0; above_on = 0;
        look; cmp("R9 fault clears burst", burst_mode, 1'b0);
        cmp("R9 no exit pulse", valley_set1, 1'b0); cmp("R9 gate low", gate_req, 1'b0);
        cyc(10); fault = 1; cyc(1); fault = 0;
        cyc(B - 1); look; cmp("R9 fault restarts window", burst_mode, 1'b0);
        cyc(1); look; cmp("R1 entry after restart", burst_mode, 1'b1);

        // mixed patterns against the model
        for (int i = 0; i < 3000; i++) begin
            below_entry = ($urandom_range(0, 9) < 8);
            valley      = ($urandom_range(0, 19) == 0) ? 3'd5 : 3'd7;
            above_on    = ($urandom_range(0, 9) == 0);
            below_off   = ($urandom_range(0, 14) == 0);
            above_leave = ($urandom_range(0, 79) == 0);
            cs_trip     = ($urandom_range(0, 11) == 0);
            tick        = ($urandom_range(0, 4) != 0);
            fault       = ($urandom_range(0, 299) == 0);
            cyc(1);
        end
        fault = 0;
        cyc(2);
        summary();
    end
endmodule